// File: doc/BRIEF.md
# Frequency Acquisition Sweep Controller

This block drives the digital control code of a recovered-clock oscillator while the phase loop is trying to capture an incoming serial stream. Starting from a programmable start code, it steps the code upward to the positive limit and then downward to the negative limit. The limits stand for plus and minus ten percent of the oscillator centre frequency, with code 0 as the centre. At the bottom it rests for a fixed dwell and then starts rising again. The cycle repeats until the loop reports capture.

The controller holds its code steady whenever the phase loop reports capture or the lock detector reports lock, so that the analog loop can track on its own. When the data-present input drops, it freezes completely: the code, the sweep direction, the step prescaler and the dwell progress all stay where they are. When data returns, acquisition resumes from the rate that was in use before the outage. One step is taken every `TICK_DIV` active clocks. `STEP` and `TICK_DIV` are chosen so that one sweep spans the intended sweep time, and `DWELL_TICKS` sets the dwell in step periods.

Top module: `freq_sweep_ctrl`

## Requirements
- R1: After reset the code equals `START_CODE` (0 by default) and the direction is upward; with data present and no lock, `sweeping` is 1.
- R2: While active (data present, no phase capture, no lock), the code changes once every `TICK_DIV` active clocks and rises by exactly `STEP` per change on the upward leg.
- R3: The code never leaves the range -`FULLSCALE`..+`FULLSCALE`; a step that would pass a limit lands exactly on that limit.
- R4: Once the code reaches +`FULLSCALE`, the following steps go downward by `STEP`.
- R5: Once the code reaches -`FULLSCALE`, it stays there with `dwelling` = 1 for `DWELL_TICKS` step periods, then rises by `STEP` and repeats the up/down cycle indefinitely.
- R6: While `data_present` is 0, the code, the direction, the prescaler phase and the dwell count are frozen; when data returns, stepping continues exactly where it stopped.
- R7: While `lock_in` or `phase_locked` is 1, the code holds steady; when both return to 0, the sweep resumes from the held code in the same direction.
- R8: Exactly one of `sweeping`, `dwelling` and `holding` is 1 at any time; `holding` is 1 whenever any hold condition of R6 or R7 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_present | input | 1 | Input transitions are being detected |
| phase_locked | input | 1 | Phase loop reports capture |
| lock_in | input | 1 | Lock detector reports valid lock |
| freq_code | output | CODE_W | Two's-complement oscillator offset code, 0 at centre |
| sweeping | output | 1 | Code is stepping up or down |
| dwelling | output | 1 | Code is resting at the negative limit |
| holding | output | 1 | Code is frozen by data loss, capture or lock |

## Verification
The hardest situation to reach is an outage that starts halfway through a prescaler period: a fault that restarts the prescaler shows up only as a step that comes one active clock early or late. The stimulus runs one active clock past a step, removes data for many clocks, restores it and checks the code exactly one active clock later. The limit clipping on both sides and the dwell exit are reached by choosing a full-scale value that is not a multiple of the step, and by counting step periods from the last clipped value.

// File: rtl/freq_sweep_ctrl.sv
module freq_sweep_ctrl #(
  parameter int CODE_W      = 12,
  parameter int FULLSCALE   = 1000,
  parameter int STEP        = 8,
  parameter int TICK_DIV    = 4,
  parameter int DWELL_TICKS = 200,
  parameter int START_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_present,
  input  logic              phase_locked,
  input  logic              lock_in,
  output logic [CODE_W-1:0] freq_code,
  output logic              sweeping,
  output logic              dwelling,
  output logic              holding
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int DW_W  = (DWELL_TICKS > 1) ? $clog2(DWELL_TICKS) : 1;
  localparam logic signed [CODE_W:0] FS_POS = (CODE_W+1)'(FULLSCALE);
  localparam logic signed [CODE_W:0] FS_NEG = -(CODE_W+1)'(FULLSCALE);
  localparam logic signed [CODE_W:0] STEP_X = (CODE_W+1)'(STEP);
  localparam logic signed [CODE_W:0] START_X = (CODE_W+1)'(START_CODE);

  typedef enum logic [1:0] {LEG_UP, LEG_DOWN, LEG_DWELL} leg_t;

  leg_t                    leg_q;
  logic signed [CODE_W:0]  code_q;
  logic signed [CODE_W:0]  up_sum, dn_sum;
  logic [DW_W-1:0]         dwell_q;
  logic                    run, tick;

  assign run    = data_present & ~phase_locked & ~lock_in;
  assign up_sum = code_q + STEP_X;
  assign dn_sum = code_q - STEP_X;

  generate
    if (TICK_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      assign tick = run && (pre_q == PRE_W'(TICK_DIV-1));
      always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else if (run)  pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign tick = run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leg_q   <= LEG_UP;
      code_q  <= START_X;
      dwell_q <= '0;
    end else if (tick) begin
      unique case (leg_q)
        LEG_UP: begin
          if (up_sum >= FS_POS) begin
            code_q <= FS_POS;
            leg_q  <= LEG_DOWN;
          end else begin
            code_q <= up_sum;
          end
        end
        LEG_DOWN: begin
          if (dn_sum <= FS_NEG) begin
            code_q  <= FS_NEG;
            leg_q   <= LEG_DWELL;
            dwell_q <= '0;
          end else begin
            code_q <= dn_sum;
          end
        end
        default: begin
          if (dwell_q == DW_W'(DWELL_TICKS-1)) begin
            dwell_q <= '0;
            leg_q   <= LEG_UP;
            code_q  <= up_sum;
          end else begin
            dwell_q <= dwell_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign freq_code = code_q[CODE_W-1:0];
  assign holding   = ~run;
  assign dwelling  = run & (leg_q == LEG_DWELL);
  assign sweeping  = run & (leg_q != LEG_DWELL);

endmodule

// File: rtl/freq_sweep_ctrl_chk.sv
module freq_sweep_ctrl_chk #(
  parameter int CODE_W    = 12,
  parameter int FULLSCALE = 1000,
  parameter int STEP      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_present,
  input logic              phase_locked,
  input logic              lock_in,
  input logic [CODE_W-1:0] freq_code,
  input logic              sweeping,
  input logic              dwelling,
  input logic              holding
);

  logic signed [CODE_W:0] cur_x, prv_x, diff_x;
  logic                   hold_cond;

  assign cur_x     = (CODE_W+1)'($signed(freq_code));
  assign diff_x    = cur_x - prv_x;
  assign hold_cond = !data_present || lock_in || phase_locked;

  always_ff @(posedge clk) prv_x <= cur_x;

  // R6, R7: a hold condition keeps the code unchanged at the next edge
  a_r7_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cond |=> $stable(freq_code));

  // R3: code within the limits
  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_x <= (CODE_W+1)'(FULLSCALE)) && (cur_x >= -(CODE_W+1)'(FULLSCALE)));

  // R2: no change larger than one step
  a_r2_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_code) |-> ((diff_x <= (CODE_W+1)'(STEP)) && (diff_x >= -(CODE_W+1)'(STEP))));

  // R8: one status at a time, holding tracks the hold inputs
  a_r8_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sweeping, dwelling, holding}) && (holding == hold_cond));

  // R5: dwell only at the negative limit
  a_r5_dwell_floor: assert property (@(posedge clk) disable iff (!rst_n)
    dwelling |-> (cur_x == -(CODE_W+1)'(FULLSCALE)));

endmodule

bind freq_sweep_ctrl freq_sweep_ctrl_chk #(
  .CODE_W(CODE_W), .FULLSCALE(FULLSCALE), .STEP(STEP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .data_present(data_present),
  .phase_locked(phase_locked), .lock_in(lock_in), .freq_code(freq_code),
  .sweeping(sweeping), .dwelling(dwelling), .holding(holding)
);

// File: tb/freq_sweep_ctrl_tb.sv
module freq_sweep_ctrl_tb_top;
  localparam int CW = 8;
  localparam int FS = 30;
  localparam int ST = 8;
  localparam int TD = 2;
  localparam int DW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_present = 1'b1;
  logic phase_locked = 1'b0;
  logic lock_in = 1'b0;
  logic [CW-1:0] freq_code;
  logic sweeping, dwelling, holding;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  freq_sweep_ctrl #(.CODE_W(CW), .FULLSCALE(FS), .STEP(ST), .TICK_DIV(TD),
                    .DWELL_TICKS(DW), .START_CODE(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .data_present(data_present),
    .phase_locked(phase_locked), .lock_in(lock_in), .freq_code(freq_code),
    .sweeping(sweeping), .dwelling(dwelling), .holding(holding));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic steps(input int n);
    clocks(n * TD);
  endtask

  task automatic code_is(input string req, input int exp);
    chk(req, int'($signed(freq_code)), exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    clocks(3);
    rst_n = 1'b1;
    code_is("R1 reset code", 0);
    chk("R1 reset sweeping", sweeping, 1);
    chk("R8 reset holding", holding, 0);
  endtask

  task automatic t_up_leg;
    clocks(1);
    code_is("R2 no step before prescale", 0);
    clocks(1);
    code_is("R2 first step", 8);
    steps(1); code_is("R2 step", 16);
    steps(1); code_is("R2 step", 24);
    steps(1); code_is("R3 clip at top", 30);
    steps(1); code_is("R4 reversal", 22);
  endtask

  task automatic t_loss_midtick;
    clocks(1);
    data_present = 1'b0;
    clocks(40);
    code_is("R6 frozen code", 22);
    chk("R6 holding on loss", holding, 1);
    chk("R8 not sweeping on loss", sweeping, 0);
    data_present = 1'b1;
    clocks(1);
    code_is("R6 prescale phase kept", 14);
    chk("R8 sweeping resumed", sweeping, 1);
  endtask

  task automatic t_down_leg;
    steps(1); code_is("R4 down", 6);
    steps(1); code_is("R4 down", -2);
    steps(3); code_is("R4 down", -26);
    steps(1); code_is("R3 clip at bottom", -30);
    chk("R5 dwelling", dwelling, 1);
  endtask

  task automatic t_dwell;
    steps(DW - 1);
    code_is("R5 still dwelling", -30);
    chk("R5 dwelling flag", dwelling, 1);
    steps(1);
    code_is("R5 leaves dwell", -22);
    chk("R5 sweeping after dwell", sweeping, 1);
  endtask

  task automatic t_lock_hold;
    lock_in = 1'b1;
    clocks(30);
    code_is("R7 lock holds", -22);
    chk("R8 holding on lock", holding, 1);
    lock_in = 1'b0;
    steps(1); code_is("R7 resume after lock", -14);
    phase_locked = 1'b1;
    clocks(20);
    code_is("R7 capture holds", -14);
    phase_locked = 1'b0;
    steps(1); code_is("R7 resume after capture", -6);
  endtask

  task automatic t_second_cycle;
    steps(4); code_is("R5 second rise", 26);
    steps(1); code_is("R3 top again", 30);
    steps(1); code_is("R5 repeats down", 22);
  endtask

  initial begin
    t_reset();
    t_up_leg();
    t_loss_midtick();
    t_down_leg();
    t_dwell();
    t_lock_hold();
    t_second_cycle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clocks(20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule